// File: doc/BRIEF.md
# Two-Instruction Complement-Write Processor

This block is an 8-bit processor that works directly on memory and has a 15-bit byte address. A program is a loop of up to 128 four-byte instructions held in the lowest 512 bytes. Each instruction names two full operand addresses, S and Q. Every instruction ends by writing a result back to Q, and that result is always the bitwise complement of an internal accumulator.

The high bit of the fourth instruction byte chooses between two operations. The first is a complemented move. The second is a complemented add. When the add carries out of eight bits, the loop skips ahead to the start of the next group of eight instructions. The program counter cannot be loaded, so this skip is the only form of branch. The loop repeats forever.

The final slot of the loop has a special role when it holds a move. In that case the processor writes nothing. Instead it raises a one-cycle exchange pulse, so that an outside device can take the Q value off the bus and put its own byte in its place. The memory sits outside the block. It is read combinationally and written on the write strobe. A status output marks the first cycle of each instruction, which is the point where an external agent can safely stop the clock.

Top module: `twin_op_cpu`

## Requirements
- R1: While reset is high, and in the first cycle after it, the address is 0, the write strobe is low, the exchange pulse is low and the boundary status is high.
- R2: Instruction n takes seven cycles. Its addresses are, in order: 4n, 4n+1, the S operand, 4n+2, 4n+3, then the Q operand twice. The next instruction begins on the following cycle.
- R3: An operand address is made as {low 7 bits of the odd byte, even byte}. The top bit of byte 1 is ignored.
- R4: When the top bit of byte 3 is 0 (move), Q becomes 255 − S, and no skip ever follows.
- R5: When the top bit of byte 3 is 1 (add), Q becomes 255 − ((S + Q) mod 256). This also holds when S and Q name the same location.
- R6: An add whose sum exceeds 255 makes the next instruction the first one of the following group of eight, that is, the first whose index is a multiple of 8. A sum of exactly 255 causes no skip.
- R7: A skip from the last instruction of a group passes over the whole next group. A skip from the final slot (127) wraps around and lands at instruction 8.
- R8: A move in slot 127 writes nothing. In its seventh cycle it raises the exchange pulse for exactly one cycle, and Q is left untouched.
- R9: An add in slot 127 writes normally and raises no exchange pulse.
- R10: The write strobe is high only in the seventh cycle of an instruction. In that cycle the write data is the result.
- R11: The boundary status is high exactly in the first cycle of each instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 15 | Byte address |
| mem_rdata | input | 8 | Read data, combinational from memory |
| mem_wdata | output | 8 | Write data (complement of the accumulator) |
| mem_we | output | 1 | Write strobe |
| xchg_pulse | output | 1 | Exchange notify, final slot only |
| dbg_ok | output | 1 | Instruction boundary; safe point to halt |

## Verification
A wrong internal state shows up on the address bus within one instruction. A fault in the step counter or in the pass bit moves the byte-fetch addresses, or shifts the cycle in which the operand addresses appear. A bad carry flag or a bad skip shows at the next instruction boundary, as a fetch address with the wrong group. A bad accumulator shows as wrong write data in the seventh cycle. A bad loop-end flag shows at slot 127, as a write strobe where the exchange pulse should be, or as a pulse where a write should be.

// File: rtl/twin_op_cpu.sv
module twin_op_cpu #(
  parameter int DW   = 8,
  parameter int SEGW = 7,
  parameter int BLKW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [SEGW+DW-1:0]   mem_addr,
  input  logic [DW-1:0]        mem_rdata,
  output logic [DW-1:0]        mem_wdata,
  output logic                 mem_we,
  output logic                 xchg_pulse,
  output logic                 dbg_ok
);
  localparam int HI = DW - BLKW;

  typedef enum logic [1:0] {ST_LO, ST_HI, ST_OPND, ST_WR} step_t;

  step_t           step;
  logic [DW-1:0]   pc, near_q, acc;
  logic [SEGW-1:0] seg_q;
  logic            qual_q, br_q, last_q;
  logic [DW:0]     sum;
  logic            pass2, pc_sel, io_slot;

  assign pass2   = pc[0];
  assign pc_sel  = (step == ST_LO) || (step == ST_HI);
  assign sum     = {1'b0, acc} + {1'b0, mem_rdata};
  assign io_slot = last_q && !qual_q;

  assign mem_addr   = pc_sel ? {{(SEGW-1){1'b0}}, pc, step == ST_HI} : {seg_q, near_q};
  assign mem_wdata  = ~acc;
  assign mem_we     = (step == ST_WR) && !io_slot;
  assign xchg_pulse = (step == ST_WR) && io_slot;
  assign dbg_ok     = (step == ST_LO) && !pass2;

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= ST_LO;
      pc     <= '0;
      near_q <= '0;
      acc    <= '0;
      seg_q  <= '0;
      qual_q <= 1'b0;
      br_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      case (step)
        ST_LO: begin
          near_q <= mem_rdata;
          step   <= ST_HI;
        end
        ST_HI: begin
          seg_q <= mem_rdata[SEGW-1:0];
          if (pass2) qual_q <= mem_rdata[DW-1];
          step <= ST_OPND;
        end
        ST_OPND: begin
          pc <= pc + 1'b1;
          if (!pass2) begin
            acc  <= mem_rdata;
            step <= ST_LO;
          end else begin
            if (qual_q) begin
              acc  <= sum[DW-1:0];
              br_q <= sum[DW];
            end else begin
              br_q <= 1'b0;
            end
            last_q <= &pc;
            step   <= ST_WR;
          end
        end
        default: begin
          if (br_q) pc <= {pc[DW-1:BLKW] + 1'b1, {BLKW{1'b0}}};
          br_q <= 1'b0;
          step <= ST_LO;
        end
      endcase
    end
  end
endmodule

// File: rtl/twin_op_cpu_chk.sv
module twin_op_cpu_chk #(
  parameter int AW     = 15,
  parameter int ALIGNW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          xchg,
  input logic          dbg,
  input logic          br,
  input logic          wr_step
);
  p_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $stable(mem_addr));

  p_io_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && xchg));

  p_xchg_single_r8: assert property (@(posedge clk) disable iff (rst)
    xchg |=> (!xchg && dbg));

  p_we_then_boundary_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && dbg));

  p_boundary_fetch_r11: assert property (@(posedge clk) disable iff (rst)
    dbg |-> (mem_addr[1:0] == 2'b00 && mem_addr[AW-1:9] == '0));

  p_boundary_next_r2: assert property (@(posedge clk) disable iff (rst)
    dbg |=> (!dbg && mem_addr[1:0] == 2'b01 && $stable(mem_addr[AW-1:2])));

  p_skip_align_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_step && br) |=> (mem_addr[ALIGNW-1:0] == '0));
endmodule

bind twin_op_cpu twin_op_cpu_chk #(.AW(SEGW+DW), .ALIGNW(BLKW+1)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .xchg(xchg_pulse), .dbg(dbg_ok), .br(br_q), .wr_step(mem_we | xchg_pulse)
);

// File: tb/tb_twin_op_cpu.sv
module tb_twin_op_cpu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;
  logic        mem_we, xchg_pulse, dbg_ok;
  logic [7:0]  mem [0:1023];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_op_cpu dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .xchg_pulse(xchg_pulse), .dbg_ok(dbg_ok)
  );

  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  // {S value, Q value, qualifier, expected Q result, expected skip}
  localparam logic [25:0] VEC [8] = '{
    {8'h00, 8'h55, 1'b0, 8'hFF, 1'b0},
    {8'hA5, 8'h00, 1'b0, 8'h5A, 1'b0},
    {8'hFF, 8'hFF, 1'b0, 8'h00, 1'b0},
    {8'h10, 8'h20, 1'b1, 8'hCF, 1'b0},
    {8'h80, 8'h80, 1'b1, 8'hFF, 1'b1},
    {8'hFF, 8'h01, 1'b1, 8'hFF, 1'b1},
    {8'hFE, 8'h01, 1'b1, 8'h00, 1'b0},
    {8'hC8, 8'h64, 1'b1, 8'hD3, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold_reset_and_clear();
    rst = 1'b1;
    @(posedge clk);
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
  endtask

  task automatic release_reset();
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_instr(input int n, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3);
    mem[4*n]   = b0;
    mem[4*n+1] = b1;
    mem[4*n+2] = b2;
    mem[4*n+3] = b3;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  s, q, res;
    logic        ib, sk;
    logic [14:0] exp_a [7];

    // R1 reset state
    hold_reset_and_clear();
    @(negedge clk);
    chk("R1 addr", {1'b0, mem_addr}, 16'h0);
    chk("R1 we", {15'b0, mem_we}, 16'h0);
    chk("R1 xchg", {15'b0, xchg_pulse}, 16'h0);
    chk("R1 dbg", {15'b0, dbg_ok}, 16'h1);
    release_reset();
    chk("R1 first cycle addr", {1'b0, mem_addr}, 16'h0);

    // vector walk: R2 R3 R4 R5 R6 R10 R11
    exp_a = '{15'h000, 15'h001, 15'h200, 15'h002, 15'h003, 15'h300, 15'h300};
    for (int v = 0; v < 8; v++) begin
      {s, q, ib, res, sk} = VEC[v];
      hold_reset_and_clear();
      put_instr(0, 8'h00, 8'h82, 8'h00, {ib, 7'h03});
      mem[10'h200] = s;
      mem[10'h300] = q;
      release_reset();
      for (int c = 0; c < 7; c++) begin
        chk("R2 R3 addr", {1'b0, mem_addr}, {1'b0, exp_a[c]});
        chk("R10 R11 we", {15'b0, mem_we}, {15'b0, c == 6});
        chk("R11 dbg", {15'b0, dbg_ok}, {15'b0, c == 0});
        if (c == 6) chk(ib ? "R5 wdata" : "R4 wdata", {8'h0, mem_wdata}, {8'h0, res});
        tick(1);
      end
      chk(ib ? "R5 stored" : "R4 stored", {8'h0, mem[10'h300]}, {8'h0, res});
      chk("R6 next fetch", {1'b0, mem_addr}, sk ? 16'd32 : 16'd4);
    end

    // R7 R5: same-address add at end of group 0 skips group 1
    hold_reset_and_clear();
    for (int n = 0; n < 7; n++) put_instr(n, 8'h00, 8'h02, 8'h80, 8'h02);
    put_instr(7, 8'h00, 8'h03, 8'h00, 8'h83);
    mem[10'h300] = 8'h90;
    release_reset();
    tick(56);
    chk("R7 next fetch", {1'b0, mem_addr}, 16'd64);
    chk("R5 same addr", {8'h0, mem[10'h300]}, 16'h00DF);

    // R8: move in final slot -> exchange pulse, no write
    hold_reset_and_clear();
    for (int n = 0; n < 127; n++) put_instr(n, 8'h00, 8'h02, 8'h80, 8'h02);
    put_instr(127, 8'h00, 8'h02, 8'h00, 8'h03);
    mem[10'h300] = 8'h3C;
    release_reset();
    tick(894);
    chk("R8 xchg before", {15'b0, xchg_pulse}, 16'h0);
    tick(1);
    chk("R8 xchg", {15'b0, xchg_pulse}, 16'h1);
    chk("R8 no we", {15'b0, mem_we}, 16'h0);
    tick(1);
    chk("R8 xchg single", {15'b0, xchg_pulse}, 16'h0);
    chk("R8 Q untouched", {8'h0, mem[10'h300]}, 16'h003C);
    chk("R2 loop wrap", {1'b0, mem_addr}, 16'h0);

    // R9 R7: add in final slot with carry writes and wraps to instruction 8
    hold_reset_and_clear();
    for (int n = 0; n < 127; n++) put_instr(n, 8'h00, 8'h02, 8'h80, 8'h02);
    put_instr(127, 8'h00, 8'h02, 8'h00, 8'h83);
    mem[10'h200] = 8'hF0;
    mem[10'h300] = 8'h20;
    release_reset();
    tick(895);
    chk("R9 we", {15'b0, mem_we}, 16'h1);
    chk("R9 no xchg", {15'b0, xchg_pulse}, 16'h0);
    tick(1);
    chk("R9 stored", {8'h0, mem[10'h300]}, 16'h00EF);
    chk("R7 wrap skip", {1'b0, mem_addr}, 16'd32);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule